// File: doc/BRIEF.md
# SECDED Codec for 32-bit Words

This block protects a 32-bit data word with seven check bits, so that any single flipped bit in the 39-bit stored codeword is corrected and any two flipped bits are detected. It has two independent halves. The encoder turns a data word into its seven check bits. The decoder takes a data word and the check bits stored with it. It recomputes the check bits and forms the syndrome. It returns the corrected word together with a single-error flag and an uncorrectable-error flag.

The parity-check matrix is fixed. Every column has odd weight. Each check bit owns a one-hot column, and each data bit owns a distinct weight-three column. The columns are listed in the requirements. Correction on the decode path can be switched off with a decode-enable input, but encoding is always active. All results leave through one output register stage, which a parameter can remove.

Top module: `secded32_codec`

## Requirements
- R1: Encoding uses these data-bit columns (data bit index: column): 0:61 1:51 2:19 3:45 4:43 5:31 6:29 7:13 8:62 9:52 10:4A 11:46 12:32 13:2A 14:23 15:1A 16:2C 17:64 18:26 19:25 20:34 21:16 22:15 23:54 24:0B 25:58 26:1C 27:4C 28:38 29:0E 30:0D 31:49 (hex). Check bit k is the XOR of every data bit whose column has bit k set. A word stored with its own encoding decodes to a zero syndrome.
- R2: The recomputed-check output equals the encoding of the decode data input. The syndrome equals the stored check bits XOR the recomputed check bits. For any set of flipped codeword bits, the syndrome therefore equals the XOR of their columns, where check bit k has column 1<<k.
- R3: A zero syndrome raises no flag and passes the data word through unchanged.
- R4: With decoding enabled, a syndrome equal to the column of data bit i sets the single flag only, and the data output has bit i inverted.
- R5: With decoding enabled, a syndrome with exactly one bit set (a check-bit error) sets the single flag only, and the data passes through unchanged.
- R6: With decoding enabled, a nonzero syndrome of even weight sets the uncorrectable flag only, and the data passes through uncorrected. The two flags are never high together.
- R7: With decoding enabled, a syndrome of odd weight that matches no column (for example 0x07, 0x1F or 0x7F) sets the uncorrectable flag only, and the data passes through uncorrected.
- R8: With decoding disabled, both flags stay low and the data passes through unchanged. The recomputed check bits, the syndrome and the encoder output are still produced.
- R9: With the output stage present (default), every output reflects the inputs present at the previous rising clock edge. While the synchronous active-low reset is sampled low, every output is zero at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Synchronous active-low reset |
| enc_data_i | input | 32 | Word to encode |
| enc_chk_o | output | 7 | Check bits of enc_data_i |
| dec_en_i | input | 1 | 1 = detect and correct, 0 = bypass |
| dec_data_i | input | 32 | Data word read from storage |
| dec_chk_i | input | 7 | Check bits read from storage |
| dec_recalc_o | output | 7 | Check bits recomputed from dec_data_i |
| dec_syn_o | output | 7 | Syndrome |
| dec_data_o | output | 32 | Corrected (or passed) data word |
| dec_single_o | output | 1 | Single-bit error corrected |
| dec_dbl_o | output | 1 | Uncorrectable error detected |

## Verification
Every output is due exactly one rising edge after its inputs are applied, and a reset sampled low clears them at that same single edge. The bench applies each stimulus at a falling edge and samples all outputs at the next falling edge, so exactly one register transfer lies between drive and check. The expected check bits and syndromes come from the bench's own column table. The bench injects every single-bit error, every pair of codeword bits, unmatched odd-weight syndromes and the bypass mode.

// File: rtl/secded_pkg.sv
// Shared constants, the fixed parity-check columns and the output bundle
// type of the SECDED codec. Assumes 32 data bits and 7 check bits.
package secded_pkg;

    localparam int DATA_W = 32;
    localparam int CHK_W  = 7;
    localparam int CW_W   = DATA_W + CHK_W;

    // Bundle carried by the output stage.
    typedef struct packed {
        logic [CHK_W-1:0]  enc_chk;
        logic [CHK_W-1:0]  recalc;
        logic [CHK_W-1:0]  syn;
        logic [DATA_W-1:0] data;
        logic              single;
        logic              dbl;
    } codec_out_t;

    // Syndrome column owned by data bit idx (odd weight, all distinct).
    function automatic logic [CHK_W-1:0] data_col(input int idx);
        case (idx)
            0:  data_col = 7'h61;  1:  data_col = 7'h51;
            2:  data_col = 7'h19;  3:  data_col = 7'h45;
            4:  data_col = 7'h43;  5:  data_col = 7'h31;
            6:  data_col = 7'h29;  7:  data_col = 7'h13;
            8:  data_col = 7'h62;  9:  data_col = 7'h52;
            10: data_col = 7'h4A;  11: data_col = 7'h46;
            12: data_col = 7'h32;  13: data_col = 7'h2A;
            14: data_col = 7'h23;  15: data_col = 7'h1A;
            16: data_col = 7'h2C;  17: data_col = 7'h64;
            18: data_col = 7'h26;  19: data_col = 7'h25;
            20: data_col = 7'h34;  21: data_col = 7'h16;
            22: data_col = 7'h15;  23: data_col = 7'h54;
            24: data_col = 7'h0B;  25: data_col = 7'h58;
            26: data_col = 7'h1C;  27: data_col = 7'h4C;
            28: data_col = 7'h38;  29: data_col = 7'h0E;
            30: data_col = 7'h0D;  31: data_col = 7'h49;
            default: data_col = '0;
        endcase
    endfunction

    // Data bits that feed check bit k (row k of the matrix).
    function automatic logic [DATA_W-1:0] row_mask(input int k);
        logic [CHK_W-1:0] c;
        row_mask = '0;
        for (int i = 0; i < DATA_W; i++) begin
            c = data_col(i);
            row_mask[i] = c[k];
        end
    endfunction

endpackage

// File: rtl/secded_parity_gen.sv
// Parity network: computes the CHK_W check bits of a data word from the
// fixed matrix rows. Purely combinational; one instance per use.
module secded_parity_gen
    import secded_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CHK_W-1:0]  chk_o
);

    for (genvar k = 0; k < CHK_W; k++) begin : g_row
        localparam logic [DATA_W-1:0] ROW = row_mask(k);
        // Check bit k is the parity of the data bits in row k.
        assign chk_o[k] = ^(data_i & ROW);
    end

endmodule

// File: rtl/secded_corrector.sv
// Syndrome decoder: maps a syndrome to a data flip mask and to the single
// and uncorrectable flags. Assumes every column has odd weight, so a
// nonzero even syndrome can never be a single error.
module secded_corrector
    import secded_pkg::*;
(
    input  logic              en_i,
    input  logic [CHK_W-1:0]  syn_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o,
    output logic              single_o,
    output logic              dbl_o
);

    logic [DATA_W-1:0] flip;
    logic              data_hit;
    logic              chk_hit;
    logic              nonzero;

    for (genvar i = 0; i < DATA_W; i++) begin : g_match
        localparam logic [CHK_W-1:0] COL = data_col(i);
        // Data bit i is the culprit when the syndrome equals its column.
        assign flip[i] = (syn_i == COL);
    end

    assign data_hit = |flip;
    assign nonzero  = |syn_i;
    // A single set bit points at one of the check bits.
    assign chk_hit  = nonzero && ((syn_i & (syn_i - 1'b1)) == '0);

    // Apply the correction and classify, or bypass when disabled.
    always_comb begin
        if (en_i) begin
            data_o   = data_i ^ flip;
            single_o = data_hit | chk_hit;
            dbl_o    = nonzero & ~(data_hit | chk_hit);
        end else begin
            data_o   = data_i;
            single_o = 1'b0;
            dbl_o    = 1'b0;
        end
    end

endmodule

// File: rtl/secded_out_stage.sv
// Output stage: registers the result bundle with a synchronous active-low
// reset, or passes it straight through when REG_OUT is 0.
module secded_out_stage
    import secded_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  codec_out_t d_i,
    output codec_out_t q_o
);

    if (REG_OUT) begin : g_reg
        // Capture the bundle each edge; clear it while reset is low.
        always_ff @(posedge clk) begin
            if (!rst_n) q_o <= '0;
            else        q_o <= d_i;
        end
    end else begin : g_comb
        assign q_o = d_i;
    end

endmodule

// File: rtl/secded32_codec.sv
// SECDED codec top: 32-bit encoder and decoder sharing one fixed odd-weight
// parity-check matrix, followed by an optional output register stage.
// Assumes stored check bits were produced by the same matrix.
module secded32_codec
    import secded_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic [CHK_W-1:0]  enc_chk_o,
    input  logic              dec_en_i,
    input  logic [DATA_W-1:0] dec_data_i,
    input  logic [CHK_W-1:0]  dec_chk_i,
    output logic [CHK_W-1:0]  dec_recalc_o,
    output logic [CHK_W-1:0]  dec_syn_o,
    output logic [DATA_W-1:0] dec_data_o,
    output logic              dec_single_o,
    output logic              dec_dbl_o
);

    logic [CHK_W-1:0]  enc_chk_c;
    logic [CHK_W-1:0]  recalc_c;
    logic [CHK_W-1:0]  syn_c;
    logic [DATA_W-1:0] data_c;
    logic              single_c;
    logic              dbl_c;
    codec_out_t        bundle_d;
    codec_out_t        bundle_q;

    secded_parity_gen i_enc_par (
        .data_i (enc_data_i),
        .chk_o  (enc_chk_c)
    );

    secded_parity_gen i_dec_par (
        .data_i (dec_data_i),
        .chk_o  (recalc_c)
    );

    // Syndrome: stored check bits against those recomputed on read.
    assign syn_c = dec_chk_i ^ recalc_c;

    secded_corrector i_corr (
        .en_i     (dec_en_i),
        .syn_i    (syn_c),
        .data_i   (dec_data_i),
        .data_o   (data_c),
        .single_o (single_c),
        .dbl_o    (dbl_c)
    );

    // Gather all results for the output stage.
    always_comb begin
        bundle_d.enc_chk = enc_chk_c;
        bundle_d.recalc  = recalc_c;
        bundle_d.syn     = syn_c;
        bundle_d.data    = data_c;
        bundle_d.single  = single_c;
        bundle_d.dbl     = dbl_c;
    end

    secded_out_stage #(.REG_OUT(REG_OUT)) i_out (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (bundle_d),
        .q_o   (bundle_q)
    );

    assign enc_chk_o    = bundle_q.enc_chk;
    assign dec_recalc_o = bundle_q.recalc;
    assign dec_syn_o    = bundle_q.syn;
    assign dec_data_o   = bundle_q.data;
    assign dec_single_o = bundle_q.single;
    assign dec_dbl_o    = bundle_q.dbl;

    // R1: a word read back with its own encoding shows a zero syndrome.
    a_r1_roundtrip_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_data_i == enc_data_i && dec_chk_i == enc_chk_c) |-> syn_c == '0);

    // R3: zero syndrome means no flag and untouched data.
    a_r3_zero_syndrome_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (syn_c == '0) |-> (!single_c && !dbl_c && data_c == dec_data_i));

    // R4: a data-column hit changes exactly one data bit.
    a_r4_one_bit_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (single_c && !$onehot(syn_c)) |-> $countones(data_c ^ dec_data_i) == 1);

    // R5: a check-bit error is flagged single and leaves data alone.
    a_r5_check_bit_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en_i && $onehot(syn_c)) |-> (single_c && !dbl_c && data_c == dec_data_i));

    // R6: nonzero even-weight syndromes are uncorrectable.
    a_r6_even_weight_dbl: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en_i && syn_c != '0 && ($countones(syn_c) % 2) == 0) |-> (dbl_c && !single_c));

    // R6: the registered flags are never high together.
    a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_single_o && dec_dbl_o));

    // R8: bypass raises no flag and passes the read word through.
    a_r8_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_en_i |-> (!single_c && !dbl_c && data_c == dec_data_i));

endmodule

// File: tb/test_secded32_codec.sv
`timescale 1ns/1ps
module test_secded32_codec;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] enc_data_i = '0;
    logic [6:0]  enc_chk_o;
    logic        dec_en_i = 1'b1;
    logic [31:0] dec_data_i = '0;
    logic [6:0]  dec_chk_i = '0;
    logic [6:0]  dec_recalc_o;
    logic [6:0]  dec_syn_o;
    logic [31:0] dec_data_o;
    logic        dec_single_o;
    logic        dec_dbl_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    secded32_codec i_secded32_codec (
        .clk(clk), .rst_n(rst_n),
        .enc_data_i(enc_data_i), .enc_chk_o(enc_chk_o),
        .dec_en_i(dec_en_i), .dec_data_i(dec_data_i), .dec_chk_i(dec_chk_i),
        .dec_recalc_o(dec_recalc_o), .dec_syn_o(dec_syn_o),
        .dec_data_o(dec_data_o), .dec_single_o(dec_single_o), .dec_dbl_o(dec_dbl_o)
    );

    // Codeword columns: 0..31 data bits, 32..38 check bits 0..6.
    localparam logic [6:0] COLS [0:38] = '{
        7'h61, 7'h51, 7'h19, 7'h45, 7'h43, 7'h31, 7'h29, 7'h13,
        7'h62, 7'h52, 7'h4A, 7'h46, 7'h32, 7'h2A, 7'h23, 7'h1A,
        7'h2C, 7'h64, 7'h26, 7'h25, 7'h34, 7'h16, 7'h15, 7'h54,
        7'h0B, 7'h58, 7'h1C, 7'h4C, 7'h38, 7'h0E, 7'h0D, 7'h49,
        7'h01, 7'h02, 7'h04, 7'h08, 7'h10, 7'h20, 7'h40 };

    typedef struct packed {
        logic [31:0] data;
        logic [38:0] flip;
        logic        en;
    } vec_t;

    localparam vec_t VECS [0:9] = '{
        '{32'h00000000, 39'h0,                        1'b1},
        '{32'hFFFFFFFF, 39'h0,                        1'b1},
        '{32'hDEADBEEF, 39'h1 << 5,                   1'b1},
        '{32'h12345678, 39'h1 << 35,                  1'b1},
        '{32'hA5A5A5A5, (39'h1 << 0) | (39'h1 << 31), 1'b1},
        '{32'h0F0F0F0F, (39'h1 << 32) | (39'h1 << 38),1'b1},
        '{32'h80000001, (39'h1 << 17) | (39'h1 << 36),1'b1},
        '{32'h55AA33CC, 39'h1 << 31,                  1'b1},
        '{32'hC0FFEE00, 39'h1 << 9,                   1'b0},
        '{32'h13579BDF, (39'h1 << 3) | (39'h1 << 4),  1'b0} };

    function automatic logic [6:0] ref_chk(input logic [31:0] d);
        logic [6:0] c = '0;
        for (int i = 0; i < 32; i++) if (d[i]) c ^= COLS[i];
        return c;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive at a falling edge, sample one rising edge later (R9).
    task automatic apply_raw(input logic en, input logic [31:0] dd,
                             input logic [6:0] dc, input logic [6:0] esyn,
                             input logic [31:0] edata, input logic es,
                             input logic ed, input string tag);
        @(negedge clk);
        enc_data_i = ~dd;
        dec_en_i   = en;
        dec_data_i = dd;
        dec_chk_i  = dc;
        @(negedge clk);
        check(enc_chk_o == ref_chk(~dd), {tag, " R1 enc"}, 64'(enc_chk_o), 64'(ref_chk(~dd)));
        check(dec_recalc_o == ref_chk(dd), {tag, " R2 recalc"}, 64'(dec_recalc_o), 64'(ref_chk(dd)));
        check(dec_syn_o == esyn, {tag, " R2 syn"}, 64'(dec_syn_o), 64'(esyn));
        check(dec_data_o == edata, {tag, " data"}, 64'(dec_data_o), 64'(edata));
        check(dec_single_o == es && dec_dbl_o == ed, {tag, " flags"},
              64'({dec_single_o, dec_dbl_o}), 64'({es, ed}));
    endtask

    task automatic inject(input logic [31:0] d, input logic [38:0] f,
                          input logic en, input string tag);
        logic [6:0]  good = ref_chk(d);
        logic [31:0] dd = d ^ f[31:0];
        logic [6:0]  dc = good ^ f[38:32];
        logic [6:0]  esyn = '0;
        int n = $countones(f);
        for (int i = 0; i < 39; i++) if (f[i]) esyn ^= COLS[i];
        if (!en)         apply_raw(en, dd, dc, esyn, dd, 1'b0, 1'b0, {tag, " R8"});
        else if (n == 0) apply_raw(en, dd, dc, esyn, d,  1'b0, 1'b0, {tag, " R3"});
        else if (n == 1) apply_raw(en, dd, dc, esyn, d,  1'b1, 1'b0,
                                   {tag, (f[38:32] != 0) ? " R5" : " R4"});
        else             apply_raw(en, dd, dc, esyn, dd, 1'b0, 1'b1, {tag, " R6"});
    endtask

    task automatic expect_zero(input string tag);
        check({enc_chk_o, dec_recalc_o, dec_syn_o, dec_data_o, dec_single_o, dec_dbl_o} == '0,
              tag, 64'({dec_data_o, dec_syn_o, dec_single_o, dec_dbl_o}), 64'h0);
    endtask

    initial begin
        // R9: outputs clear while reset is held, even with busy inputs.
        enc_data_i = 32'hFFFF0000;
        dec_data_i = 32'h12345678;
        dec_chk_i  = 7'h55;
        @(negedge clk);
        @(negedge clk);
        expect_zero("R9 reset state");
        rst_n = 1'b1;

        // Table walk.
        for (int v = 0; v < 10; v++)
            inject(VECS[v].data, VECS[v].flip, VECS[v].en, $sformatf("vec%0d", v));

        // R4/R5: every single-bit error.
        for (int b = 0; b < 39; b++)
            inject(32'h6B8B4567 ^ (32'h1 << (b % 32)), 39'h1 << b, 1'b1,
                   $sformatf("single b%0d", b));

        // R6: every pair of codeword bits.
        for (int a = 0; a < 39; a++)
            for (int b = a + 1; b < 39; b++)
                inject(32'h9E3779B9 * 32'(a + 1) + 32'(b),
                       (39'h1 << a) | (39'h1 << b), 1'b1,
                       $sformatf("pair %0d,%0d", a, b));

        // R7: odd-weight syndromes that match no column.
        apply_raw(1'b1, 32'hCAFEF00D, ref_chk(32'hCAFEF00D) ^ 7'h7F, 7'h7F,
                  32'hCAFEF00D, 1'b0, 1'b1, "R7 syn 7F");
        apply_raw(1'b1, 32'h01234567, ref_chk(32'h01234567) ^ 7'h07, 7'h07,
                  32'h01234567, 1'b0, 1'b1, "R7 syn 07");
        apply_raw(1'b1, 32'h89ABCDEF, ref_chk(32'h89ABCDEF) ^ 7'h1F, 7'h1F,
                  32'h89ABCDEF, 1'b0, 1'b1, "R7 syn 1F");
        // R8: same unmatched syndrome in bypass.
        apply_raw(1'b0, 32'hCAFEF00D, ref_chk(32'hCAFEF00D) ^ 7'h7F, 7'h7F,
                  32'hCAFEF00D, 1'b0, 1'b0, "R8 bypass 7F");

        // R9: reset mid-run clears a single-error result at the next edge.
        @(negedge clk);
        dec_en_i   = 1'b1;
        dec_data_i = 32'hFFFFFFFE;
        dec_chk_i  = ref_chk(32'hFFFFFFFF);
        rst_n      = 1'b0;
        @(negedge clk);
        expect_zero("R9 mid reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(dec_single_o && dec_data_o == 32'hFFFFFFFF, "R9 after reset R4",
              64'(dec_data_o), 64'hFFFFFFFF);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule